// File: doc/BRIEF.md
# Time-of-Day Counter with Reloadable Prescaler

This block keeps the time of day in hours, minutes and seconds. A 21-bit down-counter divides the incoming RTC clock. Each time the counter passes zero it reloads a value that software chooses and produces one second tick. The ticks advance the seconds, minutes and hours counters. Seconds and minutes wrap after 59 and carry. Hours wrap after 23.

Software works through a small register port: a control word, the reload value, a time-holding register, and a flag register. Setting the start bit starts the block. A run status then follows the start bit on fixed RTC clock edges. When run rises, the block copies the holding register into the counters. While running, software can request a time load with the update bit; the load takes place on the next second tick. Three sticky flags record second ticks, minute carries and hour carries. Software clears a flag by writing 0 to its bit.

Top module: `rtc_tod`

## Requirements
- R1: With reload value N (not zero) and run high, a second tick occurs every N+1 clock cycles. Each tick advances the seconds counter by one.
- R2: While the reload value is zero, the prescaler holds, no second tick occurs, run never rises and the time counters do not change.
- R3: When a second tick, a minute carry or an hour carry sets a flag on the same edge that software writes 0 to that flag, the flag ends up set.
- R4: Writing 1 to the update bit (control bit 1) makes the update pending. The next second tick loads the holding register into the counters and clears the update bit. If a write of 1 to the update bit falls on the edge of that completion, the update bit ends up cleared.
- R5: A write of 1 to the update bit while the seconds counter reads 59 is refused. The update bit stays 0, and the next tick increments the time normally.
- R6: On the edge where run rises, the hours, minutes and seconds counters load the holding register.
- R7: After the edge that writes start (control bit 0) to 0, run falls on the second following clock edge.
- R8: After start is set, the prescaler counts down from the reload value N. Run rises on the edge where the count equals N shifted right by one. This happens N - (N>>1) + 1 edges after the write edge.
- R9: While run is low, the time counters hold their value and the prescaler is held at the reload value. Loading a zero holding value and starting again restarts the clock from 00:00:00.
- R10: Seconds and minutes wrap from 59 to 0 and carry to the next counter. Hours wrap from 23 to 0.
- R11: Flag register bit 0 records a second tick, bit 1 a minute carry and bit 2 an hour carry. Writing 0 to a bit clears it. Writing 1 leaves it unchanged.
- R12: Register addresses: 0 is control (bit 0 start, bit 1 update; the read value also shows run in bit 2); 1 is the reload value; 2 is time (seconds in bits 5:0, minutes in 13:8, hours in 20:16), where a write goes to the holding register and a read returns the counters; 3 is the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| hours | output | 5 | Hours counter |
| minutes | output | 6 | Minutes counter |
| seconds | output | 6 | Seconds counter |
| run | output | 1 | Run status |
| flags | output | 3 | Sticky flags: hour carry, minute carry, second tick |

## Verification
Two pairs of events can fall on the same edge. The first pair is a second tick and a software write of 0 to the second flag. The second pair is the completion of a pending update and a fresh write of 1 to the update bit. The bench uses a short reload value and counts clock edges from a known start, so that it can place the register write exactly on the tick edge. The set-wins rule passes if the second flag reads 1 after that edge. The clear-wins rule passes if the update bit reads 0 and the time shows the loaded value.

// File: rtl/rtc_tod.sv
module rtc_tod #(
  parameter int PRE_W  = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        hours,
  output logic [5:0]        minutes,
  output logic [5:0]        seconds,
  output logic              run,
  output logic [2:0]        flags
);
  localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_TIME = 2'd2, A_FLAG = 2'd3;
  localparam logic [5:0] LAST_MS = 6'd59;
  localparam logic [4:0] LAST_H  = 5'd23;

  logic             start, upd, st_q;
  logic [PRE_W-1:0] reload, cnt;
  logic [4:0]       hold_h;
  logic [5:0]       hold_m, hold_s;

  wire ctrl_wr   = wr_en && wr_addr == A_CTRL;
  wire reload_wr = wr_en && wr_addr == A_RELOAD;
  wire time_wr   = wr_en && wr_addr == A_TIME;
  wire flag_wr   = wr_en && wr_addr == A_FLAG;

  wire counting  = (start || run) && (reload != '0);
  wire at_zero   = cnt == '0;
  wire at_half   = cnt == (reload >> 1);
  wire tick      = run && counting && at_zero;
  wire run_up    = start && !run && counting && at_half;
  wire run_dn    = run && !start && !st_q;
  wire s_wrap    = seconds == LAST_MS;
  wire m_wrap    = minutes == LAST_MS;
  wire h_wrap    = hours == LAST_H;
  wire load_time = run_up || (tick && upd);
  wire min_carry = tick && !upd && s_wrap;
  wire hr_carry  = min_carry && m_wrap;

  logic unused_bits;
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b0; upd <= 1'b0; st_q <= 1'b0; run <= 1'b0;
      reload <= '0; cnt <= '0;
      hold_h <= '0; hold_m <= '0; hold_s <= '0;
      hours <= '0; minutes <= '0; seconds <= '0;
      flags <= '0;
    end else begin
      st_q <= start;
      if (ctrl_wr)   start  <= wr_data[0];
      if (reload_wr) reload <= wr_data[PRE_W-1:0];
      if (time_wr) begin
        hold_s <= wr_data[5:0];
        hold_m <= wr_data[13:8];
        hold_h <= wr_data[20:16];
      end

      if (!counting || at_zero) cnt <= reload;
      else                      cnt <= cnt - 1'b1;

      if (run_dn)      run <= 1'b0;
      else if (run_up) run <= 1'b1;

      if (load_time) begin
        seconds <= hold_s; minutes <= hold_m; hours <= hold_h;
      end else if (tick) begin
        seconds <= s_wrap ? '0 : seconds + 1'b1;
        if (s_wrap) minutes <= m_wrap ? '0 : minutes + 1'b1;
        if (s_wrap && m_wrap) hours <= h_wrap ? '0 : hours + 1'b1;
      end

      if (tick && upd) upd <= 1'b0;
      else if (ctrl_wr && wr_data[1] && !s_wrap) upd <= 1'b1;

      flags <= (flag_wr ? (flags & wr_data[2:0]) : flags) | {hr_carry, min_carry, tick};
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = DATA_W'({run, upd, start});
      A_RELOAD: rd_data = DATA_W'(reload);
      A_TIME:   rd_data = DATA_W'({hours, 2'b00, minutes, 2'b00, seconds});
      default:  rd_data = DATA_W'(flags);
    endcase
  end

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0) |=> ($stable(seconds) && $stable(minutes) && $stable(hours)));
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags[0]);
  assert_flag_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags)));
  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[1] && s_wrap && !upd) |=> !upd);
  assert_rise_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (seconds == $past(hold_s) && minutes == $past(hold_m) && hours == $past(hold_h)));
  assert_run_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !st_q) |=> !run);
  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !upd && seconds < LAST_MS) |=> (seconds == $past(seconds) + 6'd1));
endmodule

// File: tb/rtc_tod_tb_top.sv
module rtc_tod_tb_top;
  localparam int CLK_PERIOD = 10;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  hours;
  logic [5:0]  minutes, seconds;
  logic        run;
  logic [2:0]  flags;
  int checks = 0, fails = 0;
  logic [31:0] snap;

  rtc_tod dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hours(hours), .minutes(minutes), .seconds(seconds),
    .run(run), .flags(flags));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] tv(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] now_t();
    return tv(int'(hours), int'(minutes), int'(seconds));
  endfunction

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 reset time", now_t(), 0);
    chk("R12 reset run", 32'(run), 0);
    chk("R11 reset flags", 32'(flags), 0);
    rd(2'd0, v); chk("R12 reset ctrl", v, 0);
  endtask

  task automatic t_zero_reload();
    wr(2'd0, 32'h1);
    edges(40);
    chk("R2 run stays low", 32'(run), 0);
    chk("R2 time frozen", now_t(), 0);
    wr(2'd0, 32'h0);
    edges(3);
  endtask

  task automatic t_start_wrap_flags();
    wr(2'd1, 32'd9);
    wr(2'd2, tv(23, 59, 58));
    wr(2'd0, 32'h1);                       // e0
    edges(5); chk("R8 run low before half", 32'(run), 0);
    edges(1); chk("R8 run high at half", 32'(run), 1);
    chk("R6 load on run rise", now_t(), tv(23, 59, 58));
    edges(3); chk("R1 no tick early", now_t(), tv(23, 59, 58));
    edges(1); chk("R1 tick after period", now_t(), tv(23, 59, 59));
    chk("R11 second flag", 32'(flags), 1);
    edges(10); chk("R10 full wrap", now_t(), tv(0, 0, 0));
    chk("R11 carry flags", 32'(flags), 7);
    wr(2'd3, 32'h0);                       // e21
    chk("R11 clear by zero", 32'(flags), 0);
    edges(8);
    wr(2'd3, 32'h0);                       // e30, coincides with tick
    chk("R3 set wins over clear", 32'(flags), 1);
    chk("R1 second tick", now_t(), tv(0, 0, 1));
  endtask

  task automatic t_update();
    logic [31:0] v;
    wr(2'd2, tv(10, 20, 30));              // e31
    wr(2'd0, 32'h3);                       // e32
    rd(2'd0, v); chk("R4 update pending", v, 7);
    edges(7); chk("R4 no load before tick", now_t(), tv(0, 0, 1));
    edges(1); chk("R4 load at tick", now_t(), tv(10, 20, 30));
    rd(2'd0, v); chk("R4 update cleared", v, 5);
    wr(2'd2, tv(5, 6, 7));                 // e41
    wr(2'd0, 32'h3);                       // e42
    edges(7);
    wr(2'd0, 32'h3);                       // e50, coincides with completion
    chk("R4 coincident load", now_t(), tv(5, 6, 7));
    rd(2'd0, v); chk("R4 completion wins", v, 5);
  endtask

  task automatic t_refuse59();
    logic [31:0] v;
    wr(2'd2, tv(1, 2, 58));                // e51
    wr(2'd0, 32'h3);                       // e52
    edges(8); chk("R4 load 58", now_t(), tv(1, 2, 58));
    edges(10); chk("R1 reach 59", now_t(), tv(1, 2, 59));
    wr(2'd2, tv(7, 7, 7));
    wr(2'd0, 32'h3);                       // sec still 59
    rd(2'd0, v); chk("R5 update refused", v, 5);
    edges(8); chk("R5 normal increment", now_t(), tv(1, 3, 0));
    chk("R10 minute carry flag", 32'(flags) & 32'h2, 2);
  endtask

  task automatic t_stop_restart();
    logic [31:0] v;
    wr(2'd0, 32'h0);                       // s0
    chk("R7 run high after 0 edges", 32'(run), 1);
    edges(1); chk("R7 run high after 1 edge", 32'(run), 1);
    edges(1); chk("R7 run low after 2 edges", 32'(run), 0);
    edges(30); chk("R9 frozen while stopped", now_t(), tv(1, 3, 0));
    rd(2'd3, v);
    wr(2'd3, 32'h7);
    chk("R11 write one keeps", 32'(flags), v);
    wr(2'd3, 32'h0);
    chk("R11 clear all", 32'(flags), 0);
    wr(2'd1, 32'd19);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1);                       // E0
    edges(10); chk("R8 run low, reload 19", 32'(run), 0);
    edges(1); chk("R8 run rises, reload 19", 32'(run), 1);
    chk("R9 cleared start", now_t(), 0);
    edges(8); chk("R1 longer period hold", now_t(), 0);
    edges(1); chk("R1 longer period tick", now_t(), tv(0, 0, 1));
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    t_reset();
    t_zero_reload();
    t_start_wrap_flags();
    t_update();
    t_refuse59();
    t_stop_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule